// File: doc/BRIEF.md
# Bus Cycle Strobe and Acknowledge Sequencer

This block times a single access from a 32-bit asynchronous-handshake processor bus to a display controller peripheral. All of its registers change on the falling edge of the processor clock. A chip-select, already synchronized to that clock, starts a three-bit state counter while the address strobe is asserted. The read/write level is captured when the counter leaves idle. It decides which peripheral strobe, read or write, is pulsed at fixed counter states.

After the strobe, the block drives both transfer-size acknowledge lines back to the processor. The processor inserts wait states until it sees them. It then removes the address strobe, and the block clears everything and returns to idle. If the address strobe goes away early, the access is treated as aborted and the block drops to idle on that edge.

The sequence is idle, setup, two strobe states, acknowledge, then hold until the address strobe is negated. The strobe ends on the edge where the acknowledge starts. All outputs are active low.

Top module: `bus_ack_seq`

## Requirements
- R1: While reset is low, and on the edge after any reset, the read strobe, the write strobe and both acknowledge bits are high (negated). Reset acts at once, without waiting for a clock edge.
- R2: The sequence starts only at a falling edge where `sel_n` is 0 and `as_n` is 0. In every other case the block stays idle and all outputs stay high.
- R3: `rw` is sampled at the start edge. A value of 1 selects the read strobe and 0 selects the write strobe. Changes of `rw` after the start edge have no effect on which strobe is driven.
- R4: `rd_stb_n` and `wr_stb_n` are never low at the same time.
- R5: Count the start edge as edge 1. The selected strobe is low after edges 2 and 3 only, so it lasts two clock cycles.
- R6: Both acknowledge bits go low together after edge 4. At that edge, and for as long as they stay low, both strobes are high.
- R7: The acknowledge bits stay low until the first falling edge at which `as_n` is 1. At that edge every output returns high and the block is idle.
- R8: If `as_n` is 1 at any falling edge while a sequence is running, the block goes idle at that edge and negates every output (abort).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; the block acts on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Synchronized peripheral select, active low |
| rw | input | 1 | Transfer direction: 1 read, 0 write |
| as_n | input | 1 | Processor address strobe, active low |
| rd_stb_n | output | 1 | Peripheral read strobe, active low |
| wr_stb_n | output | 1 | Peripheral write strobe, active low |
| ack_n | output | ACK_W | Transfer-size acknowledge lines to the processor, active low |

## Verification
The assertions are checked on every falling edge. They cover the following:
- The two strobes are never active together.
- The strobes are off whenever the acknowledge is active.
- An idle block with no valid start stays idle.
- A negated address strobe clears every output on the next edge.
- The acknowledge holds while the address strobe stays asserted.

Other behaviours need the bench's processor model to show them:
- The exact edge on which the strobe begins and ends.
- The edge on which the acknowledge first appears.
- How long the acknowledge lasts across different wait lengths.
- That the direction is latched against a mid-cycle change.
- How an abort at each early stage truncates the strobe.

// File: rtl/bus_ack_seq.sv
module bus_ack_seq #(
  parameter int ACK_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             rw,
  input  logic             as_n,
  output logic             rd_stb_n,
  output logic             wr_stb_n,
  output logic [ACK_W-1:0] ack_n
);

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_SETUP = 3'd1,
    S_STB_A = 3'd2,
    S_STB_B = 3'd3,
    S_ACK   = 3'd4,
    S_HOLD  = 3'd5
  } st_t;

  st_t  st, nxt;
  logic rw_q, rd_q, wr_q, ack_q;

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE:  if (!sel_n && !as_n) nxt = S_SETUP;
      S_SETUP: nxt = S_STB_A;
      S_STB_A: nxt = S_STB_B;
      S_STB_B: nxt = S_ACK;
      S_ACK:   nxt = S_HOLD;
      S_HOLD:  nxt = S_HOLD;
      default: nxt = S_IDLE;
    endcase
    if (st != S_IDLE && as_n) nxt = S_IDLE;
  end

  wire rw_nxt    = (st == S_IDLE) ? rw : rw_q;
  wire strobe_on = (nxt == S_STB_A) || (nxt == S_STB_B);
  wire ack_on    = (nxt == S_ACK) || (nxt == S_HOLD);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      rw_q  <= 1'b1;
      rd_q  <= 1'b1;
      wr_q  <= 1'b1;
      ack_q <= 1'b1;
    end else begin
      st    <= nxt;
      rw_q  <= rw_nxt;
      rd_q  <= !(strobe_on && rw_nxt);
      wr_q  <= !(strobe_on && !rw_nxt);
      ack_q <= !ack_on;
    end
  end

  assign rd_stb_n = rd_q;
  assign wr_stb_n = wr_q;
  assign ack_n    = {ACK_W{ack_q}};

  assert_one_strobe_R4: assert property (@(negedge clk) disable iff (!rst_n)
    !(!rd_stb_n && !wr_stb_n));

  assert_quiet_during_ack_R6: assert property (@(negedge clk) disable iff (!rst_n)
    (ack_n != {ACK_W{1'b1}}) |-> (rd_stb_n && wr_stb_n));

  assert_no_false_start_R2: assert property (@(negedge clk) disable iff (!rst_n)
    (st == S_IDLE && (sel_n || as_n)) |=> (st == S_IDLE && rd_stb_n && wr_stb_n));

  assert_abort_clears_R8: assert property (@(negedge clk) disable iff (!rst_n)
    (st != S_IDLE && as_n) |=> (rd_stb_n && wr_stb_n && ack_n == {ACK_W{1'b1}}));

  assert_ack_holds_R7: assert property (@(negedge clk) disable iff (!rst_n)
    (ack_n == {ACK_W{1'b0}} && !as_n) |=> (ack_n == {ACK_W{1'b0}}));

endmodule

// File: tb/bus_ack_seq_bench.sv
module bus_ack_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic rw = 1'b1;
  logic as_n = 1'b1;
  logic rd_stb_n, wr_stb_n;
  logic [1:0] ack_n;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  bus_ack_seq #(.ACK_W(2)) u_bus_ack_seq (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rw(rw), .as_n(as_n),
    .rd_stb_n(rd_stb_n), .wr_stb_n(wr_stb_n), .ack_n(ack_n)
  );

  // {rw, flip_rw_after_start, hold_cycles[3:0], abort_after_edge[3:0]}
  localparam logic [9:0] VEC [9] = '{
    {1'b1, 1'b0, 4'd0, 4'd0},
    {1'b0, 1'b0, 4'd0, 4'd0},
    {1'b1, 1'b0, 4'd3, 4'd0},
    {1'b0, 1'b0, 4'd2, 4'd0},
    {1'b1, 1'b1, 4'd0, 4'd0},
    {1'b0, 1'b1, 4'd1, 4'd0},
    {1'b1, 1'b0, 4'd0, 4'd1},
    {1'b0, 1'b0, 4'd0, 4'd2},
    {1'b1, 1'b0, 4'd0, 4'd3}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int quiet();
    return (rd_stb_n && wr_stb_n && ack_n == 2'b11) ? 1 : 0;
  endfunction

  task automatic run(input logic r, input logic flip, input int hold, input int abort_k,
                     output int rdc, output int wrc, output int ackc,
                     output int ackfirst, output int both, output int idle_ok);
    int hc = hold;
    bit released = 0;
    rdc = 0; wrc = 0; ackc = 0; ackfirst = 0; both = 0; idle_ok = 0;
    @(posedge clk);
    sel_n = 1'b0; as_n = 1'b0; rw = r;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk); #1;
      if (released) begin
        idle_ok = quiet();
        break;
      end
      if (!rd_stb_n) rdc++;
      if (!wr_stb_n) wrc++;
      if (!rd_stb_n && !wr_stb_n) both++;
      if (ack_n != 2'b11) begin
        ackc++;
        if (ackfirst == 0) ackfirst = k;
      end
      @(posedge clk);
      if (flip && k == 1) rw = ~rw;
      if (abort_k == k) begin
        as_n = 1'b1; sel_n = 1'b1; released = 1;
      end else if (ack_n != 2'b11) begin
        if (hc == 0) begin
          as_n = 1'b1; sel_n = 1'b1; released = 1;
        end else hc--;
      end
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int rdc, wrc, ackc, ackfirst, both, idle_ok, scnt, exp_ack, exp_first;
    repeat (3) @(negedge clk);
    #1 chk("R1 outputs negated in reset", quiet(), 1);
    @(posedge clk); rst_n = 1'b1;
    @(negedge clk); #1 chk("R1 idle after reset", quiet(), 1);

    foreach (VEC[i]) begin
      logic r, fl;
      int hold, ab;
      {r, fl} = VEC[i][9:8];
      hold = int'(VEC[i][7:4]);
      ab = int'(VEC[i][3:0]);
      run(r, fl, hold, ab, rdc, wrc, ackc, ackfirst, both, idle_ok);
      if (ab == 0) begin
        scnt = 2; exp_ack = 1 + hold; exp_first = 4;
      end else begin
        scnt = (ab - 1 > 2) ? 2 : ab - 1; exp_ack = 0; exp_first = 0;
      end
      chk("R3 R5 read strobe cycles", rdc, r ? scnt : 0);
      chk("R3 R5 write strobe cycles", wrc, r ? 0 : scnt);
      chk("R4 strobes overlap", both, 0);
      chk("R6 first acknowledge edge", ackfirst, exp_first);
      chk(ab == 0 ? "R7 acknowledge cycles" : "R8 acknowledge after abort", ackc, exp_ack);
      chk(ab == 0 ? "R7 idle after strobe negated" : "R8 idle after abort", idle_ok, 1);
    end

    // R2: select without address strobe, and address strobe without select
    @(posedge clk); sel_n = 1'b0; as_n = 1'b1; rw = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1 chk("R2 no start without as_n", quiet(), 1);
    end
    @(posedge clk); sel_n = 1'b1; as_n = 1'b0; rw = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1 chk("R2 no start without sel_n", quiet(), 1);
    end
    @(posedge clk); as_n = 1'b1;

    // R1: asynchronous reset in the middle of a strobe
    @(posedge clk); sel_n = 1'b0; as_n = 1'b0; rw = 1'b1;
    repeat (2) @(negedge clk);
    #1 chk("R5 strobe active before reset", int'(rd_stb_n), 0);
    @(posedge clk); rst_n = 1'b0; #1;
    chk("R1 async reset clears outputs", quiet(), 1);
    sel_n = 1'b1; as_n = 1'b1;
    @(posedge clk); rst_n = 1'b1;
    @(negedge clk); #1 chk("R1 stays idle after reset", quiet(), 1);

    // back-to-back access after recovery
    run(1'b0, 1'b0, 0, 0, rdc, wrc, ackc, ackfirst, both, idle_ok);
    chk("R5 write after reset", wrc, 2);
    chk("R6 acknowledge edge after reset", ackfirst, 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule